// File: doc/BRIEF.md
# Wave Control and Timed-Stall Unit

This unit carries out the scalar control instructions of a single wave that do not redirect the program counter. It receives an already decoded 7-bit opcode, a 16-bit immediate, a valid strobe and a privilege level. From these it updates the wave state it owns: a halt flag, a kill flag, a 2-bit priority, a 32-bit mode word, a 32-bit M0 word and a bank of sixteen 16-bit event counters. Messages, traps, barriers and trace data are handled elsewhere. For those, and for the instruction-cache invalidate, the unit only raises a one-cycle request.

Two instructions stall the wave for a time taken from the immediate. The no-op waits a few cycles, and the sleep waits in steps of 64 cycles. A small state machine tracks the stall. In `ST_IDLE` it accepts a strobe. It moves `ST_IDLE -> ST_STALL` when an accepted stall instruction has a nonzero length, and loads a down-counter with that length. It stays in `ST_STALL` while the counter is above one. It moves `ST_STALL -> ST_IDLE` on the cycle the counter reads one. `busy_o` is high exactly while the machine is in `ST_STALL`, and any strobe seen during that time is dropped.

A strobe is accepted when `instr_valid` is 1 and `busy_o` is 0. Every effect of an accepted instruction becomes visible on the outputs in the cycle after acceptance.

Top module: `wave_ctrl_unit`

## Requirements
- R1: After reset, `halt_o`, `kill_o`, `prio_o`, every counter and every request output read 0, and `busy_o` is 0. `m0_o` reads parameter `M0_INIT` and `mode_o` reads parameter `MODE_INIT`; both parameters default to zero.
- R2: An accepted opcode 0 (no-op) drives `busy_o` high for exactly imm[2:0]+1 consecutive cycles, starting in the cycle after acceptance.
- R3: An accepted opcode 14 (sleep) drives `busy_o` high for exactly imm[2:0]*64 cycles, starting in the cycle after acceptance. A value of 0 leaves `busy_o` low.
- R4: While `busy_o` is high, a strobe is ignored: no state output changes and no request pulse appears.
- R5: Opcode 13 writes imm[0] into `halt_o` when `priv` is 0. When `priv` is 1, it leaves `halt_o` unchanged.
- R6: Opcode 11 writes imm[0] into `kill_o`. Opcode 15 writes imm[1:0] into `prio_o`.
- R7: Opcode 20 adds one to, and opcode 21 subtracts one from, the counter selected by imm[3:0]. Counter k occupies `perf_o[16k+15:16k]`. The counters wrap modulo 2^16, and no other counter changes.
- R8: Opcode 29 replaces `m0_o[15:12]` with imm[3:0] and keeps all other M0 bits.
- R9: Opcode 28 clears `mode_o[27]` and keeps all other mode bits.
- R10: Opcode 19 raises `icache_inv_o` for exactly one cycle, the cycle after acceptance.
- R11: Single-cycle requests follow acceptance in the same way:
  - opcode 10 raises `barrier_req_o`;
  - opcodes 16 and 17 raise `msg_req_o`;
  - opcode 18 raises `trap_req_o`;
  - opcode 22 raises `trace_req_o`.
- R12: Any other opcode (for example 1, 3, 12 or 127) changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction strobe |
| opcode | input | 7 | Decoded control opcode |
| imm | input | 16 | Immediate field |
| priv | input | 1 | Privileged mode; blocks halt writes |
| busy_o | output | 1 | High while a timed stall runs |
| halt_o | output | 1 | Halt flag |
| kill_o | output | 1 | Kill flag |
| prio_o | output | 2 | Wave priority |
| mode_o | output | 32 | Mode word |
| m0_o | output | 32 | M0 word |
| perf_o | output | 256 | Sixteen 16-bit counters, counter k in bits 16k+15:16k |
| icache_inv_o | output | 1 | Instruction-cache invalidate pulse |
| msg_req_o | output | 1 | Message request pulse |
| trap_req_o | output | 1 | Trap request pulse |
| barrier_req_o | output | 1 | Barrier request pulse |
| trace_req_o | output | 1 | Trace-data request pulse |

## Verification
The two functions that meet in one cycle are the stall countdown releasing `busy_o` and the arrival of a new strobe. The bench starts a four-cycle no-op and sends strobes on the second and on the last busy cycle; both must leave the kill flag, the priority and the counters untouched. It then sends a strobe one cycle after release, which must take effect. A second collision pairs a halt write with the privilege input, with the instruction issued both privileged and unprivileged. Each case is judged on the outputs against a cycle-stamped model of the state and the `busy_o` trace.

// File: rtl/wcu_pkg.sv
package wcu_pkg;

    typedef enum logic [6:0] {
        OP_NOP      = 7'd0,
        OP_BARRIER  = 7'd10,
        OP_SETKILL  = 7'd11,
        OP_SETHALT  = 7'd13,
        OP_SLEEP    = 7'd14,
        OP_SETPRIO  = 7'd15,
        OP_MSG      = 7'd16,
        OP_MSGHALT  = 7'd17,
        OP_TRAP     = 7'd18,
        OP_ICINV    = 7'd19,
        OP_PERFINC  = 7'd20,
        OP_PERFDEC  = 7'd21,
        OP_TRACE    = 7'd22,
        OP_IDXOFF   = 7'd28,
        OP_IDXMODE  = 7'd29
    } wcu_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_STALL = 1'b1
    } wcu_stall_e;

    typedef struct packed {
        logic wr_halt;
        logic wr_kill;
        logic wr_prio;
        logic perf_inc;
        logic perf_dec;
        logic idx_mode;
        logic idx_off;
        logic icinv;
        logic msg;
        logic trap;
        logic barrier;
        logic trace;
    } wcu_dec_t;

endpackage

// File: rtl/wcu_decode.sv
module wcu_decode
    import wcu_pkg::*;
#(
    parameter int unsigned NOP_BITS   = 3,
    parameter int unsigned SLEEP_BITS = 3,
    parameter int unsigned SLEEP_UNIT = 64,
    parameter int unsigned CNT_W      = 9
) (
    input  logic                  take,
    input  logic [6:0]            opcode,
    input  logic [NOP_BITS-1:0]   nop_f,
    input  logic [SLEEP_BITS-1:0] sleep_f,
    output wcu_dec_t              dec,
    output logic                  stall_load,
    output logic [CNT_W-1:0]      stall_len
);

    always_comb begin
        dec        = '0;
        stall_load = 1'b0;
        stall_len  = '0;
        if (take) begin
            case (opcode)
                OP_NOP: begin
                    stall_load = 1'b1;
                    stall_len  = CNT_W'(nop_f) + CNT_W'(1);
                end
                OP_SLEEP: begin
                    stall_load = 1'b1;
                    stall_len  = CNT_W'(sleep_f) * CNT_W'(SLEEP_UNIT);
                end
                OP_SETHALT: dec.wr_halt  = 1'b1;
                OP_SETKILL: dec.wr_kill  = 1'b1;
                OP_SETPRIO: dec.wr_prio  = 1'b1;
                OP_PERFINC: dec.perf_inc = 1'b1;
                OP_PERFDEC: dec.perf_dec = 1'b1;
                OP_IDXMODE: dec.idx_mode = 1'b1;
                OP_IDXOFF:  dec.idx_off  = 1'b1;
                OP_ICINV:   dec.icinv    = 1'b1;
                OP_MSG,
                OP_MSGHALT: dec.msg      = 1'b1;
                OP_TRAP:    dec.trap     = 1'b1;
                OP_BARRIER: dec.barrier  = 1'b1;
                OP_TRACE:   dec.trace    = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wcu_stall_fsm.sv
module wcu_stall_fsm
    import wcu_pkg::*;
#(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             busy
);

    wcu_stall_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (load && (len != '0)) begin
                    st_d  = ST_STALL;
                    cnt_d = len;
                end
            end
            ST_STALL: begin
                if (cnt_q == CNT_W'(1)) begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign busy = (st_q == ST_STALL);

endmodule

// File: rtl/wcu_state_regs.sv
module wcu_state_regs
    import wcu_pkg::*;
#(
    parameter logic [31:0] M0_INIT   = 32'h0,
    parameter logic [31:0] MODE_INIT = 32'h0,
    parameter int unsigned PRIO_W    = 2,
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned IDX_LSB   = 12,
    parameter int unsigned OFF_BIT   = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wcu_dec_t          dec,
    input  logic [IDX_W-1:0]  imm_lo,
    input  logic              priv,
    output logic              halt_o,
    output logic              kill_o,
    output logic [PRIO_W-1:0] prio_o,
    output logic [31:0]       mode_o,
    output logic [31:0]       m0_o,
    output logic              icache_inv_o,
    output logic              msg_req_o,
    output logic              trap_req_o,
    output logic              barrier_req_o,
    output logic              trace_req_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_o <= 1'b0;
            kill_o <= 1'b0;
            prio_o <= '0;
            mode_o <= MODE_INIT;
            m0_o   <= M0_INIT;
        end else begin
            if (dec.wr_halt && !priv) halt_o <= imm_lo[0];
            if (dec.wr_kill)          kill_o <= imm_lo[0];
            if (dec.wr_prio)          prio_o <= imm_lo[PRIO_W-1:0];
            if (dec.idx_mode)         m0_o[IDX_LSB +: IDX_W] <= imm_lo;
            if (dec.idx_off)          mode_o[OFF_BIT] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            icache_inv_o  <= 1'b0;
            msg_req_o     <= 1'b0;
            trap_req_o    <= 1'b0;
            barrier_req_o <= 1'b0;
            trace_req_o   <= 1'b0;
        end else begin
            icache_inv_o  <= dec.icinv;
            msg_req_o     <= dec.msg;
            trap_req_o    <= dec.trap;
            barrier_req_o <= dec.barrier;
            trace_req_o   <= dec.trace;
        end
    end

endmodule

// File: rtl/wcu_perf_bank.sv
module wcu_perf_bank #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned CTR_W = 16,
    localparam int unsigned NCTR = 1 << IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc,
    input  logic                  dec,
    input  logic [IDX_W-1:0]      sel,
    output logic [NCTR*CTR_W-1:0] cnt_o
);

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        logic [CTR_W-1:0] val_q;
        logic             hit;

        assign hit = (sel == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (inc && hit) begin
                val_q <= val_q + CTR_W'(1);
            end else if (dec && hit) begin
                val_q <= val_q - CTR_W'(1);
            end
        end

        assign cnt_o[g*CTR_W +: CTR_W] = val_q;
    end

endmodule

// File: rtl/wave_ctrl_unit.sv
module wave_ctrl_unit
    import wcu_pkg::*;
#(
    parameter logic [31:0] M0_INIT    = 32'h0,
    parameter logic [31:0] MODE_INIT  = 32'h0,
    parameter int unsigned NOP_BITS   = 3,
    parameter int unsigned SLEEP_BITS = 3,
    parameter int unsigned SLEEP_UNIT = 64,
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned CTR_W      = 16,
    localparam int unsigned NCTR      = 1 << IDX_W,
    localparam int unsigned MAX_STALL = ((1 << SLEEP_BITS) - 1) * SLEEP_UNIT,
    localparam int unsigned CNT_W     = $clog2(MAX_STALL + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_valid,
    input  logic [6:0]            opcode,
    input  logic [15:0]           imm,
    input  logic                  priv,
    output logic                  busy_o,
    output logic                  halt_o,
    output logic                  kill_o,
    output logic [1:0]            prio_o,
    output logic [31:0]           mode_o,
    output logic [31:0]           m0_o,
    output logic [NCTR*CTR_W-1:0] perf_o,
    output logic                  icache_inv_o,
    output logic                  msg_req_o,
    output logic                  trap_req_o,
    output logic                  barrier_req_o,
    output logic                  trace_req_o
);

    logic             take;
    wcu_dec_t         dec;
    logic             stall_load;
    logic [CNT_W-1:0] stall_len;
    logic             unused_imm;

    assign take       = instr_valid && !busy_o;
    assign unused_imm = ^imm[15:IDX_W];

    wcu_decode #(
        .NOP_BITS  (NOP_BITS),
        .SLEEP_BITS(SLEEP_BITS),
        .SLEEP_UNIT(SLEEP_UNIT),
        .CNT_W     (CNT_W)
    ) u_dec (
        .take      (take),
        .opcode    (opcode),
        .nop_f     (imm[NOP_BITS-1:0]),
        .sleep_f   (imm[SLEEP_BITS-1:0]),
        .dec       (dec),
        .stall_load(stall_load),
        .stall_len (stall_len)
    );

    wcu_stall_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .load (stall_load),
        .len  (stall_len),
        .busy (busy_o)
    );

    wcu_state_regs #(
        .M0_INIT  (M0_INIT),
        .MODE_INIT(MODE_INIT),
        .PRIO_W   (2),
        .IDX_W    (IDX_W),
        .IDX_LSB  (12),
        .OFF_BIT  (27)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec          (dec),
        .imm_lo       (imm[IDX_W-1:0]),
        .priv         (priv),
        .halt_o       (halt_o),
        .kill_o       (kill_o),
        .prio_o       (prio_o),
        .mode_o       (mode_o),
        .m0_o         (m0_o),
        .icache_inv_o (icache_inv_o),
        .msg_req_o    (msg_req_o),
        .trap_req_o   (trap_req_o),
        .barrier_req_o(barrier_req_o),
        .trace_req_o  (trace_req_o)
    );

    wcu_perf_bank #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_perf (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (dec.perf_inc),
        .dec  (dec.perf_dec),
        .sel  (imm[IDX_W-1:0]),
        .cnt_o(perf_o)
    );

endmodule

// File: rtl/wcu_checker.sv
module wcu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [6:0]  opcode,
    input logic [15:0] imm,
    input logic        priv,
    input logic        busy_o,
    input logic        halt_o,
    input logic        kill_o,
    input logic [1:0]  prio_o,
    input logic [31:0] mode_o,
    input logic [31:0] m0_o,
    input logic        icache_inv_o
);

    logic take;
    assign take = instr_valid && !busy_o;

    // R2
    assert_nop_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && opcode == 7'd0) |=> busy_o);

    // R3
    assert_zero_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && opcode == 7'd14 && imm[2:0] == 3'd0) |=> !busy_o);

    // R4
    assert_busy_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(halt_o) && $stable(kill_o) && $stable(prio_o)
                    && $stable(mode_o) && $stable(m0_o) && !icache_inv_o));

    // R5
    assert_priv_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && opcode == 7'd13 && priv) |=> $stable(halt_o));

    // R6
    assert_prio_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && opcode == 7'd15) |=> (prio_o == $past(imm[1:0])));

    assert_kill_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && opcode == 7'd11) |=> (kill_o == $past(imm[0])));

    // R8
    assert_m0_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && opcode == 7'd29) |=> (m0_o[15:12] == $past(imm[3:0])
            && m0_o[31:16] == $past(m0_o[31:16]) && m0_o[11:0] == $past(m0_o[11:0])));

    // R9
    assert_mode_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && opcode == 7'd28) |=> (!mode_o[27]
            && mode_o[26:0] == $past(mode_o[26:0]) && mode_o[31:28] == $past(mode_o[31:28])));

    // R10
    assert_icinv_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        icache_inv_o |-> $past(take && opcode == 7'd19));

endmodule

bind wave_ctrl_unit wcu_checker u_chk (.*);

// File: tb/wave_ctrl_unit_test.sv
`timescale 1ns/1ps
module wave_ctrl_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [6:0]   opcode = '0;
    logic [15:0]  imm = '0;
    logic         priv = 1'b0;
    logic         busy_o, halt_o, kill_o;
    logic [1:0]   prio_o;
    logic [31:0]  mode_o, m0_o;
    logic [255:0] perf_o;
    logic         icache_inv_o, msg_req_o, trap_req_o, barrier_req_o, trace_req_o;

    localparam logic [31:0] M0_START   = 32'hDEAD_BEEF;
    localparam logic [31:0] MODE_START = 32'hFFFF_FFFF;

    wave_ctrl_unit #(.M0_INIT(M0_START), .MODE_INIT(MODE_START)) uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
        .imm(imm), .priv(priv), .busy_o(busy_o), .halt_o(halt_o), .kill_o(kill_o),
        .prio_o(prio_o), .mode_o(mode_o), .m0_o(m0_o), .perf_o(perf_o),
        .icache_inv_o(icache_inv_o), .msg_req_o(msg_req_o), .trap_req_o(trap_req_o),
        .barrier_req_o(barrier_req_o), .trace_req_o(trace_req_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          at;
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;

    // reference model of the wave state
    logic        m_halt = 0, m_kill = 0;
    logic [1:0]  m_prio = 0;
    logic [31:0] m_mode = MODE_START, m_m0 = M0_START;
    logic [15:0] m_perf [16];
    int          busy_end = -1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] get(int sel);
        case (sel)
            0:  return {31'd0, busy_o};
            1:  return {31'd0, halt_o};
            2:  return {31'd0, kill_o};
            3:  return {30'd0, prio_o};
            4:  return mode_o;
            5:  return m0_o;
            6:  return {31'd0, icache_inv_o};
            7:  return {31'd0, msg_req_o};
            8:  return {31'd0, trap_req_o};
            9:  return {31'd0, barrier_req_o};
            10: return {31'd0, trace_req_o};
            default: return {16'd0, perf_o[(sel-16)*16 +: 16]};
        endcase
    endfunction

    task automatic push(int at, int sel, logic [31:0] e, string t);
        item_t it;
        it.at = at; it.sel = sel; it.exp = e; it.tag = t;
        q.push_back(it);
    endtask

    // monitor: compare every due item against the ports
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                logic [31:0] act;
                act = get(q[i].sel);
                n_chk++;
                if (act !== q[i].exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h",
                             q[i].tag, q[i].sel, cyc, act, q[i].exp);
                end
                q.delete(i);
            end
        end
    end

    // driver: optionally strobe an instruction and predict every output
    task automatic send(bit drv, logic [6:0] op, logic [15:0] im, logic pv, string t);
        int   a;
        bit   acc;
        int   n;
        logic [4:0] pul;
        @(negedge clk);
        a   = cyc;
        acc = drv && (a > busy_end);
        pul = '0;
        n   = 0;
        if (drv) begin
            opcode = op; imm = im; priv = pv; instr_valid = 1'b1;
        end
        if (acc) begin
            case (op)
                7'd0:  n = int'(im[2:0]) + 1;
                7'd14: n = int'(im[2:0]) * 64;
                7'd13: if (!pv) m_halt = im[0];
                7'd11: m_kill = im[0];
                7'd15: m_prio = im[1:0];
                7'd20: m_perf[im[3:0]] = m_perf[im[3:0]] + 16'd1;
                7'd21: m_perf[im[3:0]] = m_perf[im[3:0]] - 16'd1;
                7'd29: m_m0[15:12] = im[3:0];
                7'd28: m_mode[27] = 1'b0;
                7'd19: pul[0] = 1'b1;
                7'd16, 7'd17: pul[1] = 1'b1;
                7'd18: pul[2] = 1'b1;
                7'd10: pul[3] = 1'b1;
                7'd22: pul[4] = 1'b1;
                default: ;
            endcase
            if (n > 0) begin
                busy_end = a + n;
                for (int c = a + 2; c <= a + n; c++) push(c, 0, 32'd1, t);
                push(a + n + 1, 0, 32'd0, t);
            end
        end
        push(a + 1, 0, {31'd0, (a + 1 <= busy_end)}, t);
        push(a + 1, 1, {31'd0, m_halt}, t);
        push(a + 1, 2, {31'd0, m_kill}, t);
        push(a + 1, 3, {30'd0, m_prio}, t);
        push(a + 1, 4, m_mode, t);
        push(a + 1, 5, m_m0, t);
        for (int k = 0; k < 5; k++) push(a + 1, 6 + k, {31'd0, pul[k]}, t);
        for (int k = 0; k < 16; k++) push(a + 1, 16 + k, {16'd0, m_perf[k]}, t);
        if (pul != '0)
            for (int k = 0; k < 5; k++) push(a + 2, 6 + k, 32'd0, t);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic print_summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        print_summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) m_perf[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        send(0, 7'd0, 16'd0, 0, "R1");

        send(1, 7'd11, 16'h0001, 0, "R6");
        send(1, 7'd15, 16'hFFFE, 0, "R6");
        send(1, 7'd11, 16'hFFFE, 0, "R6");

        send(1, 7'd13, 16'h0001, 0, "R5");
        send(1, 7'd13, 16'h0000, 1, "R5");
        send(1, 7'd13, 16'h0000, 0, "R5");
        send(1, 7'd13, 16'h0001, 1, "R5");

        send(1, 7'd20, 16'hFFF5, 0, "R7");
        send(1, 7'd21, 16'h0003, 0, "R7");
        send(1, 7'd20, 16'h0003, 0, "R7");
        send(1, 7'd21, 16'h000F, 0, "R7");

        send(1, 7'd29, 16'h00A7, 0, "R8");
        send(1, 7'd29, 16'hFFF0, 0, "R8");

        send(1, 7'd28, 16'hFFFF, 0, "R9");
        send(1, 7'd28, 16'h0000, 0, "R9");

        send(1, 7'd19, 16'h0000, 0, "R10");
        send(1, 7'd10, 16'h0000, 0, "R11");
        send(1, 7'd16, 16'h0000, 0, "R11");
        send(1, 7'd17, 16'h0000, 0, "R11");
        send(1, 7'd18, 16'h0000, 0, "R11");
        send(1, 7'd22, 16'h0000, 0, "R11");

        send(1, 7'd1,   16'hFFFF, 0, "R12");
        send(1, 7'd3,   16'hFFFF, 0, "R12");
        send(1, 7'd12,  16'hFFFF, 0, "R12");
        send(1, 7'd127, 16'hFFFF, 0, "R12");

        send(1, 7'd0, 16'h0000, 0, "R2");
        send(0, 7'd0, 16'h0000, 0, "R2");
        send(1, 7'd0, 16'hFFFB, 0, "R2");
        send(1, 7'd11, 16'h0001, 0, "R4");
        send(1, 7'd20, 16'h0005, 0, "R4");
        send(1, 7'd15, 16'h0001, 0, "R2");

        send(1, 7'd14, 16'hFFF8, 0, "R3");
        send(1, 7'd14, 16'h0002, 0, "R3");
        send(1, 7'd19, 16'h0000, 0, "R4");
        send(1, 7'd13, 16'h0000, 0, "R4");
        repeat (140) @(negedge clk);
        send(1, 7'd14, 16'h0007, 0, "R3");
        send(1, 7'd29, 16'h0001, 0, "R4");
        repeat (460) @(negedge clk);
        send(0, 7'd0, 16'h0000, 0, "R3");

        repeat (8) @(negedge clk);
        if (q.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 pending items: actual=%0d expected=0", q.size());
        end
        print_summary();
        $finish;
    end

endmodule